// File: doc/BRIEF.md
# Single-Clock Dual-Port RAM with Defined Collision Behaviour

This block is a synchronous RAM with two ports, A and B, that share one clock. Each port has its own address, write enable, read enable and write data. Each port also has a read-data register that updates one cycle after the edge that samples a read. Two cases are left undefined by a bare inferred dual-port array, and the block defines both. The first is a read on one port while the other port writes the same word on the same edge. The result is set by a mode parameter: the reader gets the prior contents (old-data), or the read is declared unspecified and the model drives X (don't-care). The second is both ports writing one address on the same edge. An arbiter lets port A win and drops port B's write. A one-cycle flag reports that a dual write collided.

A configuration parameter reduces the RAM to a simple dual-port memory. Port A becomes write-only and port B becomes read-only. The unused read path on A and the unused write path on B are ignored. Because there is a single clock, reads and writes on the two ports are always related by the same edge. There is no state machine: every cycle is decided only by that cycle's port inputs and the array contents.

Top module: `dpram_collide`

## Requirements
- R1: A read enabled on a port at a clock edge presents the addressed word on that port's read data after that edge. While the port's read enable is low, its read data keeps its last value.
- R2: A port that reads and writes in the same cycle returns the data it is writing (write-through), provided its own write is committed.
- R3: In old-data mode (RDW_MODE = RDW_OLD), a port reading the address that the other port writes on the same edge returns the contents from before that edge. The new word appears on a later read.
- R4: In don't-care mode (RDW_MODE = RDW_DONTCARE), that same mixed-port read yields an unspecified value (X), and nothing may depend on it.
- R5: When both ports write the same address on one edge, port A's data is stored and port B's write is discarded.
- R6: wr_collide is 1 during exactly the cycle after an edge where both ports wrote the same address. Otherwise it is 0.
- R7: Writes from both ports to different addresses on the same edge are both stored.
- R8: With SIMPLE_DP = 1, a_rdata stays 0 whatever a_re does, b_we and b_wdata never change the memory, and wr_collide stays 0.
- R9: A synchronous active-high rst clears a_rdata, b_rdata and wr_collide to 0. Reset does not clear the memory contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous reset, active high |
| a_addr | input | ADDR_W | Port A word address |
| a_we | input | 1 | Port A write enable |
| a_re | input | 1 | Port A read enable |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A registered read data |
| b_addr | input | ADDR_W | Port B word address |
| b_we | input | 1 | Port B write enable |
| b_re | input | 1 | Port B read enable |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B registered read data |
| wr_collide | output | 1 | High for one cycle after a same-address dual write |

## Verification
The hardest case to reach is a read on one port aimed at the exact word the other port is writing. A harder variant combines that with port B also writing the same word and losing to port A. With 256 words, uniform random addresses almost never line up. The stimulus therefore draws most cycles from a small address window and forces equal addresses in dedicated cycle kinds: A writes while B reads, B writes while A reads, and both write with random read enables. Later reads of the contested words show which writer's data was stored.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    typedef enum logic [0:0] {
        RDW_OLD      = 1'b0,
        RDW_DONTCARE = 1'b1
    } rdw_mode_e;

endpackage

// File: rtl/dpram_store.sv
module dpram_store #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wa_en,
    input  logic [ADDR_W-1:0] wa_addr,
    input  logic [DATA_W-1:0] wa_data,
    input  logic              wb_en,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic [DATA_W-1:0] wb_data,
    input  logic [ADDR_W-1:0] ra_addr,
    output logic [DATA_W-1:0] ra_data,
    input  logic [ADDR_W-1:0] rb_addr,
    output logic [DATA_W-1:0] rb_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (wa_en) words[wa_addr] <= wa_data;
        if (wb_en) words[wb_addr] <= wb_data;
    end

    always_comb begin
        ra_data = words[ra_addr];
        rb_data = words[rb_addr];
    end

    AST_WR_DISJOINT: assert property (@(posedge clk) disable iff (rst)
        (wa_en && wb_en) |-> (wa_addr != wb_addr)); // R5

endmodule

// File: rtl/dpram_wr_arbiter.sv
module dpram_wr_arbiter #(
    parameter int ADDR_W    = 8,
    parameter bit SIMPLE_DP = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    output logic              wa_en,
    output logic              wb_en,
    output logic              collide_q
);
    logic same_addr;
    logic b_allowed;
    logic collide_now;

    always_comb begin
        same_addr   = (a_addr == b_addr);
        b_allowed   = b_we && !SIMPLE_DP;
        collide_now = a_we && b_allowed && same_addr;
        wa_en       = a_we;
        wb_en       = b_allowed && !collide_now;
    end

    always_ff @(posedge clk) begin
        if (rst) collide_q <= 1'b0;
        else     collide_q <= collide_now;
    end

    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (rst)
        collide_q |-> $past(a_we && b_we && (a_addr == b_addr))); // R6

    AST_FLAG_RAISED: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(a_we && b_we && (a_addr == b_addr)) && !SIMPLE_DP) |-> collide_q); // R6

endmodule

// File: rtl/dpram_rd_port.sv
module dpram_rd_port
    import dpram_pkg::*;
#(
    parameter int        DATA_W   = 16,
    parameter int        ADDR_W   = 8,
    parameter rdw_mode_e RDW_MODE = RDW_OLD,
    parameter bit        ENABLE   = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic              own_commit,
    input  logic [DATA_W-1:0] own_wdata,
    input  logic              peer_commit,
    input  logic [ADDR_W-1:0] peer_addr,
    input  logic [DATA_W-1:0] mem_data,
    output logic [DATA_W-1:0] rdata
);
    logic              rd_fire;
    logic              mixed_hit;
    logic [DATA_W-1:0] rd_next;

    always_comb begin
        rd_fire   = re && ENABLE;
        mixed_hit = peer_commit && (peer_addr == addr);
        if (own_commit)
            rd_next = own_wdata;
        else if (mixed_hit && RDW_MODE == RDW_DONTCARE)
            rd_next = {DATA_W{1'bx}};
        else
            rd_next = mem_data;
    end

    always_ff @(posedge clk) begin
        if (rst)          rdata <= '0;
        else if (rd_fire) rdata <= rd_next;
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(re) && !$isunknown($past(rdata))) |-> $stable(rdata)); // R1

    AST_WR_THROUGH: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(re && own_commit) && ENABLE) |-> (rdata == $past(own_wdata))); // R2

endmodule

// File: rtl/dpram_collide.sv
module dpram_collide
    import dpram_pkg::*;
#(
    parameter int        DATA_W    = 16,
    parameter int        ADDR_W    = 8,
    parameter rdw_mode_e RDW_MODE  = RDW_OLD,
    parameter bit        SIMPLE_DP = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              a_we,
    input  logic              a_re,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              b_we,
    input  logic              b_re,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              wr_collide
);
    localparam bit A_READS = !SIMPLE_DP;

    logic              wa_en;
    logic              wb_en;
    logic [DATA_W-1:0] mem_a;
    logic [DATA_W-1:0] mem_b;

    dpram_wr_arbiter #(
        .ADDR_W    (ADDR_W),
        .SIMPLE_DP (SIMPLE_DP)
    ) u_arb (
        .clk       (clk),
        .rst       (rst),
        .a_we      (a_we),
        .a_addr    (a_addr),
        .b_we      (b_we),
        .b_addr    (b_addr),
        .wa_en     (wa_en),
        .wb_en     (wb_en),
        .collide_q (wr_collide)
    );

    dpram_store #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wa_en   (wa_en),
        .wa_addr (a_addr),
        .wa_data (a_wdata),
        .wb_en   (wb_en),
        .wb_addr (b_addr),
        .wb_data (b_wdata),
        .ra_addr (a_addr),
        .ra_data (mem_a),
        .rb_addr (b_addr),
        .rb_data (mem_b)
    );

    dpram_rd_port #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .RDW_MODE (RDW_MODE),
        .ENABLE   (A_READS)
    ) u_rd_a (
        .clk         (clk),
        .rst         (rst),
        .re          (a_re),
        .addr        (a_addr),
        .own_commit  (wa_en),
        .own_wdata   (a_wdata),
        .peer_commit (wb_en),
        .peer_addr   (b_addr),
        .mem_data    (mem_a),
        .rdata       (a_rdata)
    );

    dpram_rd_port #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .RDW_MODE (RDW_MODE),
        .ENABLE   (1'b1)
    ) u_rd_b (
        .clk         (clk),
        .rst         (rst),
        .re          (b_re),
        .addr        (b_addr),
        .own_commit  (wb_en),
        .own_wdata   (b_wdata),
        .peer_commit (wa_en),
        .peer_addr   (a_addr),
        .mem_data    (mem_b),
        .rdata       (b_rdata)
    );

    AST_SDP_QUIET: assert property (@(posedge clk) disable iff (rst)
        SIMPLE_DP |-> (!wr_collide && a_rdata == '0)); // R8

endmodule

// File: tb/dpram_collide_bench.sv
module dpram_collide_bench;
    import dpram_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int AW = 8;
    localparam int DEPTH = 1 << AW;
    localparam int N_RANDOM = 4000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic          a_we = 0, a_re = 0, b_we = 0, b_re = 0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0;

    logic [DW-1:0] t_a_rd, t_b_rd, s_a_rd, s_b_rd;
    logic          t_coll, s_coll;

    dpram_collide #(.DATA_W(DW), .ADDR_W(AW), .RDW_MODE(RDW_OLD), .SIMPLE_DP(1'b0)) u_dpram_collide (
        .clk(clk), .rst(rst),
        .a_addr(a_addr), .a_we(a_we), .a_re(a_re), .a_wdata(a_wdata), .a_rdata(t_a_rd),
        .b_addr(b_addr), .b_we(b_we), .b_re(b_re), .b_wdata(b_wdata), .b_rdata(t_b_rd),
        .wr_collide(t_coll)
    );

    dpram_collide #(.DATA_W(DW), .ADDR_W(AW), .RDW_MODE(RDW_DONTCARE), .SIMPLE_DP(1'b1)) u_dpram_collide_sdp (
        .clk(clk), .rst(rst),
        .a_addr(a_addr), .a_we(a_we), .a_re(a_re), .a_wdata(a_wdata), .a_rdata(s_a_rd),
        .b_addr(b_addr), .b_we(b_we), .b_re(b_re), .b_wdata(b_wdata), .b_rdata(s_b_rd),
        .wr_collide(s_coll)
    );

    // Reference state: plain arrays, plus a note on how each word was last written.
    logic [DW-1:0] ref_t [DEPTH];
    logic [DW-1:0] ref_s [DEPTH];
    int            how_t [DEPTH]; // 0 single write, 1 lost/won collision, 2 parallel writes
    logic [DW-1:0] e_ta = '0, e_tb = '0, e_sb = '0;
    logic          e_tc = 1'b0;
    logic          sb_unknown = 1'b0;
    string         tag_a = "R9", tag_b = "R9", tag_sb = "R9";

    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string src_tag(input int how, input string dflt);
        if (how == 1) return "R5";
        if (how == 2) return "R7";
        return dflt;
    endfunction

    task automatic step(input logic [AW-1:0] aa, input logic awe, input logic are, input logic [DW-1:0] awd,
                        input logic [AW-1:0] ba, input logic bwe, input logic bre, input logic [DW-1:0] bwd);
        logic same, bcommit;
        a_addr = aa; a_we = awe; a_re = are; a_wdata = awd;
        b_addr = ba; b_we = bwe; b_re = bre; b_wdata = bwd;
        same    = (aa == ba);
        bcommit = bwe && !(awe && same);
        e_tc    = awe && bwe && same;
        if (are) begin
            if (awe) begin e_ta = awd; tag_a = "R2"; end
            else begin
                e_ta  = ref_t[aa];
                tag_a = (bcommit && same) ? "R3" : src_tag(how_t[aa], "R1");
            end
        end else tag_a = "R1";
        if (bre) begin
            if (bcommit) begin e_tb = bwd; tag_b = "R2"; end
            else begin
                e_tb  = ref_t[ba];
                tag_b = (awe && same) ? "R3" : src_tag(how_t[ba], "R1");
            end
        end else tag_b = "R1";
        if (awe) begin ref_t[aa] = awd; how_t[aa] = e_tc ? 1 : (bcommit ? 2 : 0); end
        if (bcommit) begin ref_t[ba] = bwd; how_t[ba] = awe ? 2 : 0; end
        // simple dual-port, don't-care instance
        if (bre) begin
            if (awe && same) begin sb_unknown = 1'b1; tag_sb = "R4"; end
            else begin sb_unknown = 1'b0; e_sb = ref_s[ba]; tag_sb = "R8"; end
        end
        if (awe) ref_s[aa] = awd;
        @(negedge clk);
        chk(tag_a, t_a_rd, e_ta);
        chk(tag_b, t_b_rd, e_tb);
        chk("R6", {{(DW-1){1'b0}}, t_coll}, {{(DW-1){1'b0}}, e_tc});
        chk("R8", s_a_rd, '0);
        chk("R8", {{(DW-1){1'b0}}, s_coll}, '0);
        if (!sb_unknown) chk(tag_sb, s_b_rd, e_sb);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R9", t_a_rd, '0);
        chk("R9", t_b_rd, '0);
        chk("R9", {{(DW-1){1'b0}}, t_coll}, '0);
        chk("R9", s_b_rd, '0);
        rst = 1'b0;
        // fill every word through port A
        for (int i = 0; i < DEPTH; i++)
            step(AW'(i), 1'b1, 1'b0, DW'(i * 37 + 5), '0, 1'b0, 1'b0, '0);
        // reset must keep contents (R9)
        rst = 1'b1;
        @(negedge clk);
        chk("R9", t_a_rd, '0);
        rst = 1'b0;
        e_ta = '0; e_tb = '0; e_sb = '0; sb_unknown = 1'b0;
        step(8'd10, 1'b0, 1'b1, '0, 8'd20, 1'b0, 1'b1, '0);
        // directed: dual write collision then readback on both ports
        step(8'd4, 1'b1, 1'b0, 16'hAAAA, 8'd4, 1'b1, 1'b0, 16'h5555);
        step(8'd4, 1'b0, 1'b1, '0, 8'd4, 1'b0, 1'b1, '0);
        // directed: A writes while B reads same word, then B reads again
        step(8'd7, 1'b1, 1'b0, 16'h1234, 8'd7, 1'b0, 1'b1, '0);
        step(8'd7, 1'b0, 1'b0, '0, 8'd7, 1'b0, 1'b1, '0);
        for (int n = 0; n < N_RANDOM; n++) begin
            int kind;
            logic [AW-1:0] aa, ba;
            logic awe, are, bwe, bre;
            kind = $urandom_range(0, 4);
            aa   = (kind == 0) ? AW'($urandom) : AW'($urandom_range(0, 3));
            ba   = (kind <= 1) ? AW'($urandom_range(0, 3)) : aa;
            awe  = $urandom_range(0, 1) == 1;
            are  = $urandom_range(0, 1) == 1;
            bwe  = $urandom_range(0, 1) == 1;
            bre  = $urandom_range(0, 1) == 1;
            case (kind)
                2: begin awe = 1'b1; bwe = 1'b0; bre = 1'b1; end
                3: begin bwe = 1'b1; awe = 1'b0; are = 1'b1; end
                4: begin awe = 1'b1; bwe = 1'b1; end
                default: ;
            endcase
            step(aa, awe, are, DW'($urandom), ba, bwe, bre, DW'($urandom));
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule